// File: doc/BRIEF.md
# Host-side keyboard serial port

This block sits between a processor register port and a two-wire open-drain keyboard link. The link has a clock and a data line. On the receive side it tracks falling edges of the keyboard-driven clock and assembles each frame. A frame is a low start bit, eight data bits least significant first, an odd parity bit and a high stop bit. The block checks the parity and the stop bit. A good byte is placed in a one-byte output buffer. The host finds out that data is waiting either from a status flag or from an interrupt that it can enable.

On the transmit side, the host writes a command byte to the data register. The block holds the clock line low for a programmable inhibit time, pulls the data line low as the request-to-send, and releases the clock. It then shifts the byte out on the falling edges that the keyboard supplies, adding an odd parity bit and a released stop bit. It waits for the keyboard to pull data low as the acknowledge. Until that acknowledge arrives, the input-buffer-full flag stays set and any further byte written by the host is dropped. An acknowledge timeout frees the transmit path and records an error.

Both lines are open-drain: each output port is an enable that pulls its line low, and the line reads high when no side pulls it.

Top module: `kbd_serial_host`

## Requirements
- R1: After reset, the status register reads 0x00, the interrupt request is low and neither line is pulled low.
- R2: A frame with a low start bit, odd parity over the 9 bits and a high stop bit loads its byte into the data register and sets status bit 0 (output buffer full).
- R3: A frame with wrong parity or a low stop bit is discarded and does not set status bit 0. It sets status bit 2 (receive error), which clears on the cycle after the host reads the status register.
- R4: Status bit 0 clears on the cycle after the host reads the data register.
- R5: Writing the control register (select 1) sets the interrupt enable from bit 0 of the written value. The enable reads back as status bit 4. The interrupt request is high exactly when the enable and status bit 0 are both set.
- R6: A host write to the data register (select 0) while idle sets status bit 1 (input buffer full). It holds the clock line low for exactly INHIBIT_CYC cycles, then releases the clock and pulls the data line low.
- R7: On the device's clock falling edges 1 to 8 the block presents the data bits, least significant first. Edge 9 presents the odd parity bit and edge 10 releases the data line as the stop bit.
- R8: Status bit 1 stays set until the device holds data low at the 11th falling edge. A data-register write made while it is set is ignored.
- R9: If no acknowledge arrives within ACK_TMO_CYC cycles after the request, the block releases both lines and clears status bit 1. It sets status bit 3 (timeout), which clears on the cycle after a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| kb_clk_i | input | 1 | Sensed level of the link clock line |
| kb_dat_i | input | 1 | Sensed level of the link data line |
| kb_clk_pull | output | 1 | 1 pulls the link clock line low |
| kb_dat_pull | output | 1 | 1 pulls the link data line low |
| reg_sel | input | 1 | 0 selects data register, 1 status/control |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears read-sensitive flags) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Output-buffer-full interrupt request |

## Verification
The embedded assertions check, on every cycle, the following:
- The interrupt never rises without a full output buffer.
- Reading the data register empties the buffer.
- A rejected frame never fills it.
- The pending transmit byte cannot change while a send is in flight.
- Both lines are free whenever no send is pending.
- A timeout always leaves the transmit path idle.

Only the bench scenarios can show that bits arrive on the wire in the right order with correct odd parity. They also show that the inhibit time is exact, that a good frame delivers the right byte, and that the acknowledge ends the handshake.

// File: rtl/kbd_serial_host.sv
module kbd_serial_host #(
  parameter int INHIBIT_CYC = 20000,
  parameter int ACK_TMO_CYC = 400000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kb_clk_i,
  input  logic       kb_dat_i,
  output logic       kb_clk_pull,
  output logic       kb_dat_pull,
  input  logic       reg_sel,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  localparam int CMAX = (INHIBIT_CYC > ACK_TMO_CYC) ? INHIBIT_CYC : ACK_TMO_CYC;
  localparam int CW = $clog2(CMAX + 1);

  typedef enum logic [1:0] {TX_IDLE, TX_INH, TX_REQ} tx_t;
  tx_t tx_st;

  logic [2:0] ck_s;
  logic [1:0] dt_s;
  logic [3:0] rx_cnt, tx_bit;
  logic [7:0] rx_sr, data_q, tx_byte;
  logic       rx_par, obf, rx_err, tmo_err, irq_en, tx_drive;
  logic [CW-1:0] cnt;

  wire fall    = ck_s[2] & ~ck_s[1];
  wire kd      = dt_s[1];
  wire ibf     = tx_st != TX_IDLE;
  wire rx_end  = fall && !ibf && rx_cnt == 4'd10;
  wire rx_good = rx_end && kd && ((^rx_sr) ^ rx_par);
  wire rx_bad  = rx_end && !rx_good;
  wire rd_data = reg_rd && !reg_sel;
  wire rd_stat = reg_rd && reg_sel;

  assign kb_clk_pull = tx_st == TX_INH;
  assign kb_dat_pull = tx_drive;
  assign irq         = obf & irq_en;
  assign reg_rdata   = reg_sel ? {3'b000, irq_en, tmo_err, rx_err, ibf, obf} : data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_s <= 3'b111; dt_s <= 2'b11;
      rx_cnt <= '0; rx_sr <= '0; rx_par <= 1'b0; data_q <= '0;
      obf <= 1'b0; rx_err <= 1'b0; tmo_err <= 1'b0; irq_en <= 1'b0;
      tx_st <= TX_IDLE; tx_byte <= '0; tx_bit <= '0; tx_drive <= 1'b0; cnt <= '0;
    end else begin
      ck_s <= {ck_s[1:0], kb_clk_i};
      dt_s <= {dt_s[0], kb_dat_i};

      if (rd_data) obf <= 1'b0;
      if (rd_stat) begin rx_err <= 1'b0; tmo_err <= 1'b0; end
      if (reg_wr && reg_sel) irq_en <= reg_wdata[0];

      if (ibf) rx_cnt <= '0;
      else if (fall) begin
        if (rx_cnt == 4'd0) begin
          if (!kd) rx_cnt <= 4'd1;
        end else if (rx_cnt <= 4'd8) begin
          rx_sr <= {kd, rx_sr[7:1]};
          rx_cnt <= rx_cnt + 4'd1;
        end else if (rx_cnt == 4'd9) begin
          rx_par <= kd;
          rx_cnt <= 4'd10;
        end else rx_cnt <= '0;
      end
      if (rx_good) begin data_q <= rx_sr; obf <= 1'b1; end
      if (rx_bad) rx_err <= 1'b1;

      case (tx_st)
        TX_IDLE: if (reg_wr && !reg_sel) begin
          tx_byte <= reg_wdata; tx_st <= TX_INH; cnt <= '0;
        end
        TX_INH: if (cnt == CW'(INHIBIT_CYC - 1)) begin
          tx_st <= TX_REQ; cnt <= '0; tx_bit <= '0; tx_drive <= 1'b1;
        end else cnt <= cnt + 1'b1;
        default: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(ACK_TMO_CYC - 1)) begin
            tmo_err <= 1'b1; tx_st <= TX_IDLE; tx_drive <= 1'b0;
          end else if (fall) begin
            tx_bit <= tx_bit + 4'd1;
            if (tx_bit < 4'd8) tx_drive <= ~tx_byte[tx_bit[2:0]];
            else if (tx_bit == 4'd8) tx_drive <= ^tx_byte;
            else if (tx_bit == 4'd9) tx_drive <= 1'b0;
            else if (!kd) begin tx_st <= TX_IDLE; tx_drive <= 1'b0; end
          end
        end
      endcase
    end
  end

  // R5
  irq_needs_obf_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> obf);
  // R4
  obf_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !rx_good) |=> !obf);
  // R3
  bad_frame_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_bad && !obf) |=> !obf);
  // R8
  tx_byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ibf && reg_wr && !reg_sel) |=> $stable(tx_byte));
  // R6
  lines_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ibf |-> (!kb_clk_pull && !kb_dat_pull));
  // R9
  tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_err) |-> !ibf);
endmodule

// File: tb/kbd_serial_host_tb.sv
module kbd_serial_host_tb;
  localparam int INH = 100;
  localparam int TMO = 3000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dev_clk = 1'b1, dev_dat = 1'b1;
  logic reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic kb_clk_pull, kb_dat_pull, irq;
  wire line_clk = dev_clk & ~kb_clk_pull;
  wire line_dat = dev_dat & ~kb_dat_pull;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  kbd_serial_host #(.INHIBIT_CYC(INH), .ACK_TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .kb_clk_i(line_clk), .kb_dat_i(line_dat),
    .kb_clk_pull(kb_clk_pull), .kb_dat_pull(kb_dat_pull),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  function automatic logic odd_par(input logic [7:0] b);
    return ~^b;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic s, input logic [7:0] v);
    @(negedge clk); reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic s, output logic [7:0] v);
    @(negedge clk); reg_sel = s; reg_rd = 1'b1; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic dev_bit(input logic b);
    dev_dat = b; wait_cyc(10);
    dev_clk = 1'b0; wait_cyc(20);
    dev_clk = 1'b1; wait_cyc(10);
  endtask

  task automatic dev_send(input logic [7:0] b, input logic bad_par, input logic bad_stop);
    dev_bit(1'b0);
    for (int i = 0; i < 8; i++) dev_bit(b[i]);
    dev_bit(odd_par(b) ^ bad_par);
    dev_bit(~bad_stop);
    dev_dat = 1'b1; wait_cyc(10);
  endtask

  task automatic dev_recv(input logic ack, output logic [7:0] b, output logic p, output logic s);
    int guard = 0;
    while (!kb_dat_pull && guard < 1000) begin guard++; @(negedge clk); end
    wait_cyc(10);
    for (int i = 1; i <= 10; i++) begin
      dev_clk = 1'b0; wait_cyc(20);
      dev_clk = 1'b1;
      if (i <= 8) b[i-1] = line_dat; else if (i == 9) p = line_dat; else s = line_dat;
      wait_cyc(20);
    end
    if (ack) begin
      dev_dat = 1'b0; wait_cyc(10);
      dev_clk = 1'b0; wait_cyc(20);
      dev_clk = 1'b1; wait_cyc(10);
      dev_dat = 1'b1;
    end
    wait_cyc(10);
  endtask

  task automatic rx_case(input logic [7:0] b);
    logic [7:0] v;
    dev_send(b, 1'b0, 1'b0);
    reg_read(1'b1, v);
    chk("R2 obf set", v[0], 1'b1);
    chk("R5 irq with enable", irq, 1'b1);
    reg_read(1'b0, v);
    chk("R2 data byte", v, b);
    reg_read(1'b1, v);
    chk("R4 obf cleared", v[0], 1'b0);
    chk("R5 irq dropped", irq, 1'b0);
  endtask

  task automatic tx_case(input logic [7:0] b, input logic extra_wr);
    logic [7:0] got, v; logic p, s; int n = 0;
    reg_write(1'b0, b);
    while (kb_clk_pull && n < 10 * INH) begin n++; @(negedge clk); end
    chk("R6 inhibit length", n, INH);
    chk("R6 data pulled after inhibit", kb_dat_pull, 1'b1);
    chk("R6 clock released", kb_clk_pull, 1'b0);
    reg_read(1'b1, v);
    chk("R6 ibf set", v[1], 1'b1);
    if (extra_wr) reg_write(1'b0, ~b);
    dev_recv(1'b1, got, p, s);
    chk("R7 data bits", got, b);
    chk("R7 odd parity", p, odd_par(b));
    chk("R7 stop released", s, 1'b1);
    reg_read(1'b1, v);
    chk("R8 ibf cleared by ack", v[1], 1'b0);
    if (extra_wr) begin
      wait_cyc(INH + 50);
      chk("R8 second write ignored", {kb_clk_pull, kb_dat_pull}, 2'b00);
    end
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED_1234));
    wait_cyc(5); rst_n = 1'b1; wait_cyc(3);

    reg_read(1'b1, v);
    chk("R1 status at reset", v, 8'h00);
    chk("R1 irq at reset", irq, 1'b0);
    chk("R1 lines released", {kb_clk_pull, kb_dat_pull}, 2'b00);

    reg_write(1'b1, 8'h01);
    reg_read(1'b1, v);
    chk("R5 enable readback", v[4], 1'b1);

    rx_case(8'h00); rx_case(8'hFF); rx_case(8'hA5); rx_case(8'h01);
    for (int i = 0; i < 8; i++) rx_case(8'($urandom));

    dev_send(8'h3C, 1'b1, 1'b0);
    reg_read(1'b1, v);
    chk("R3 parity error flag", v[2], 1'b1);
    chk("R3 parity frame not stored", v[0], 1'b0);
    reg_read(1'b1, v);
    chk("R3 error clears on read", v[2], 1'b0);
    dev_send(8'h5A, 1'b0, 1'b1);
    reg_read(1'b1, v);
    chk("R3 stop error flag", v[2], 1'b1);
    chk("R3 stop frame not stored", v[0], 1'b0);

    reg_write(1'b1, 8'h00);
    dev_send(8'h77, 1'b0, 1'b0);
    chk("R5 irq off when disabled", irq, 1'b0);
    reg_read(1'b1, v);
    chk("R5 poll sees obf", v[0], 1'b1);
    chk("R5 enable cleared", v[4], 1'b0);
    reg_read(1'b0, v);
    chk("R2 polled byte", v, 8'h77);

    tx_case(8'hED, 1'b0); tx_case(8'h00, 1'b1); tx_case(8'hFF, 1'b0);
    for (int i = 0; i < 4; i++) tx_case(8'($urandom), i[0]);

    reg_write(1'b0, 8'hF4);
    wait_cyc(INH + TMO - 30);
    reg_read(1'b1, v);
    chk("R9 ibf held before timeout", v[1], 1'b1);
    wait_cyc(60);
    reg_read(1'b1, v);
    chk("R9 timeout flag", v[3], 1'b1);
    chk("R9 ibf freed", v[1], 1'b0);
    chk("R9 lines released", {kb_clk_pull, kb_dat_pull}, 2'b00);
    reg_read(1'b1, v);
    chk("R9 timeout clears on read", v[3], 1'b0);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual expired expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule